// File: doc/BRIEF.md
# Nibble-Mode Parallel Link Receiver

This block receives packets over a five-wire parallel link. Four input wires carry data a nibble at a time and a fifth carries the sending peer's strobe. The block answers on its own five-wire output, where only the acknowledge wire is active. Each byte takes two nibbles. The high nibble arrives with the peer's strobe rising and the low nibble with the strobe falling. The block raises its acknowledge after it takes the first nibble and lowers it after it takes the second.

Every packet opens with a fixed two-byte type prefix, 0x08 then 0x00. The block checks this prefix and removes it, then passes the remaining bytes out on a valid/ready byte stream. There is no length field. The sender marks the end of a packet by driving the data wires to the bitwise inverse of its last nibble while leaving the strobe low. To flag the final byte, the block keeps one byte in reserve and releases it with the last flag once the end mark is seen.

A packet with a wrong prefix raises an error flag. The block still acknowledges the rest of that packet so the sender can finish, but forwards none of it. Back-pressure works at byte level. When the stream cannot take another byte, the block keeps its acknowledge high, which holds the sender on the current byte.

Top module: `nibble_link_rx`

## Requirements
- R1: After reset, `link_out` is all zero, `m_valid` is low and `hdr_err` is low.
- R2: Each input wire passes through a synchroniser. A change on `link_in` is acted on only after the synchronised value of all five wires has held still for at least STABLE_CYC consecutive cycles. A pulse shorter than that has no effect.
- R3: `link_out[4]` is the acknowledge. It rises only after the filtered peer strobe `link_in[4]` has been seen high, and falls only after the strobe has been seen low. `link_out[3:0]` is always zero.
- R4: A byte is formed as {nibble present when the strobe rises, nibble present when the strobe falls}. `link_in[0]` is the least significant data bit and `link_in[3]` the most significant.
- R5: The first two bytes of a packet are checked against 0x08 and 0x00 and are never sent out on the stream.
- R6: If a prefix byte does not match, `hdr_err` rises and stays high until the next packet starts. No byte of that packet appears on the stream, and every remaining nibble of it is still acknowledged.
- R7: While the strobe is low between bytes, data wires equal to the bitwise inverse of the last low nibble end the packet. The last payload byte then goes out with `m_last` high, and no earlier byte has `m_last` high.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold steady. When the output register and the one-byte reserve are both full, the acknowledge stays high on the next low nibble until the stream drains.
- R9: A packet that carries only the two prefix bytes produces nothing on the stream and no error.
- R10: While idle with the strobe low, changes on the data wires are ignored. A new packet starts only on a rising strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_in | input | 5 | Peer wires: [3:0] data nibble, [4] peer strobe |
| link_out | output | 5 | Own wires: [4] acknowledge, [3:0] held at zero |
| m_valid | output | 1 | Stream byte valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | 8 | Stream payload byte |
| m_last | output | 1 | Marks the final payload byte of a packet |
| hdr_err | output | 1 | Prefix mismatch seen in the current packet |

## Verification
On every cycle the assertions check three things. The filter must accept a value only after the synchronised wires have held it. The acknowledge must move only in step with the filtered strobe, and the unused output wires must stay zero. The stream must keep its byte and flag steady under back-pressure. The other behaviours can only be shown by the bench scenarios, because they depend on the order of events across a whole packet. These are the nibble order inside a byte, removal of the prefix, dropping of packets with a bad prefix, placing `m_last` on the right byte after the end mark, empty packets, glitch rejection, and the acknowledge stalling while the stream is full.

// File: rtl/nlr_pkg.sv
package nlr_pkg;
  localparam int LINE_W = 5;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int HS_BIT = 4;
  localparam logic [BYTE_W-1:0] PREFIX_B0 = 8'h08;
  localparam logic [BYTE_W-1:0] PREFIX_B1 = 8'h00;
  localparam int PREFIX_LEN = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_ENDING
  } rx_state_e;
endpackage

// File: rtl/nlr_line_filter.sv
module nlr_line_filter #(
  parameter int WIDTH       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] filt_o
);
  localparam int CNT_W   = $clog2(STABLE_CYC + 1);
  localparam int CNT_MAX = STABLE_CYC - 1;

  // per-wire synchroniser chain
  for (genvar g = 0; g < WIDTH; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = chain[SYNC_STAGES-1];
  end

  logic [WIDTH-1:0] cand_q;
  logic [CNT_W-1:0] cnt_q;

  // all wires are accepted together once they have held still
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q <= '0;
      cnt_q  <= '0;
      filt_o <= '0;
    end else if (sync_o != cand_q) begin
      cand_q <= sync_o;
      cnt_q  <= '0;
    end else if (cnt_q != CNT_W'(CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      filt_o <= cand_q;
    end
  end
endmodule

// File: rtl/nlr_deframer.sv
module nlr_deframer
  import nlr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_i,
  input  logic              stage_rdy_i,
  output logic              ack_o,
  output logic              byte_evt_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              end_evt_o,
  output logic              hdr_err_o
);
  rx_state_e        st_q;
  logic [NIB_W-1:0] upper_q;
  logic [NIB_W-1:0] last_q;
  logic [1:0]       idx_q;
  logic             drop_q;
  logic             hs_q;

  logic             hs;
  logic [NIB_W-1:0] nib;
  logic             rise;
  logic             marker;
  logic             in_prefix;
  logic [BYTE_W-1:0] expect_b;

  always_comb begin
    hs        = line_i[HS_BIT];
    nib       = line_i[NIB_W-1:0];
    rise      = hs & ~hs_q;
    marker    = ~hs && (nib == ~last_q);
    in_prefix = (idx_q < 2'(PREFIX_LEN));
    expect_b  = (idx_q == 2'd0) ? PREFIX_B0 : PREFIX_B1;
    byte_o    = {upper_q, nib};
    byte_evt_o = (st_q == ST_WAIT_LO) && !hs && !in_prefix && !drop_q && stage_rdy_i;
    end_evt_o  = (st_q == ST_ENDING) && !drop_q && stage_rdy_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      upper_q   <= '0;
      last_q    <= '0;
      idx_q     <= '0;
      drop_q    <= 1'b0;
      hs_q      <= 1'b0;
      ack_o     <= 1'b0;
      hdr_err_o <= 1'b0;
    end else begin
      hs_q <= hs;
      case (st_q)
        ST_IDLE: begin
          if (rise) begin
            upper_q   <= nib;
            ack_o     <= 1'b1;
            idx_q     <= '0;
            drop_q    <= 1'b0;
            hdr_err_o <= 1'b0;
            st_q      <= ST_WAIT_LO;
          end
        end
        ST_WAIT_HI: begin
          if (hs) begin
            upper_q <= nib;
            ack_o   <= 1'b1;
            st_q    <= ST_WAIT_LO;
          end else if (marker) begin
            st_q <= ST_ENDING;
          end
        end
        ST_WAIT_LO: begin
          if (!hs) begin
            if (in_prefix) begin
              if (byte_o != expect_b) begin
                drop_q    <= 1'b1;
                hdr_err_o <= 1'b1;
              end
              idx_q  <= idx_q + 1'b1;
              ack_o  <= 1'b0;
              last_q <= nib;
              st_q   <= ST_WAIT_HI;
            end else if (drop_q || stage_rdy_i) begin
              ack_o  <= 1'b0;
              last_q <= nib;
              st_q   <= ST_WAIT_HI;
            end
          end
        end
        ST_ENDING: begin
          if (drop_q || stage_rdy_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nlr_out_stage.sv
module nlr_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_evt_i,
  input  logic [DW-1:0] byte_i,
  input  logic          end_evt_i,
  output logic          stage_rdy_o,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          m_last
);
  logic          hold_v;
  logic [DW-1:0] hold_d;
  logic          out_v;
  logic [DW-1:0] out_d;
  logic          out_l;
  logic          move;

  assign stage_rdy_o = !hold_v || !out_v || m_ready;
  assign move        = hold_v && (byte_evt_i || end_evt_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      out_v  <= 1'b0;
      out_d  <= '0;
      out_l  <= 1'b0;
    end else begin
      if (out_v && m_ready) out_v <= 1'b0;
      if (move) begin
        out_v <= 1'b1;
        out_d <= hold_d;
        out_l <= end_evt_i;
      end
      if (byte_evt_i) begin
        hold_v <= 1'b1;
        hold_d <= byte_i;
      end else if (end_evt_i) begin
        hold_v <= 1'b0;
      end
    end
  end

  assign m_valid = out_v;
  assign m_data  = out_d;
  assign m_last  = out_v & out_l;
endmodule

// File: rtl/nibble_link_rx.sv
module nibble_link_rx
  import nlr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] link_in,
  output logic [LINE_W-1:0] link_out,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_last,
  output logic              hdr_err
);
  logic [LINE_W-1:0] sync_w;
  logic [LINE_W-1:0] filt_w;
  logic              ack;
  logic              byte_evt;
  logic [BYTE_W-1:0] byte_w;
  logic              end_evt;
  logic              stage_rdy;

  nlr_line_filter #(
    .WIDTH      (LINE_W),
    .SYNC_STAGES(SYNC_STAGES),
    .STABLE_CYC (STABLE_CYC)
  ) u_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (link_in),
    .sync_o(sync_w),
    .filt_o(filt_w)
  );

  nlr_deframer u_deframer (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (filt_w),
    .stage_rdy_i(stage_rdy),
    .ack_o      (ack),
    .byte_evt_o (byte_evt),
    .byte_o     (byte_w),
    .end_evt_o  (end_evt),
    .hdr_err_o  (hdr_err)
  );

  nlr_out_stage #(.DW(BYTE_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_evt_i (byte_evt),
    .byte_i     (byte_w),
    .end_evt_i  (end_evt),
    .stage_rdy_o(stage_rdy),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_data     (m_data),
    .m_last     (m_last)
  );

  assign link_out = {ack, {NIB_W{1'b0}}};
endmodule

// File: rtl/nibble_link_rx_chk.sv
module nibble_link_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] sync_w,
  input logic [4:0] filt_w,
  input logic [4:0] link_out,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_last
);
  // R2: a filtered value must have been present on the synchronised wires
  assert_filter_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_w) |-> (filt_w == $past(sync_w) && filt_w == $past(sync_w, 2)));

  // R3: acknowledge follows the filtered peer strobe
  assert_ack_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_out[4]) |-> $past(filt_w[4]));
  assert_ack_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_out[4]) |-> !$past(filt_w[4]));
  assert_out_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_out[3:0] == 4'h0);

  // R8: stream holds under back-pressure
  assert_stream_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
endmodule

bind nibble_link_rx nibble_link_rx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sync_w  (sync_w),
  .filt_w  (filt_w),
  .link_out(link_out),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data),
  .m_last  (m_last)
);

// File: tb/nibble_link_rx_tb.sv
module nibble_link_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] link_in = '0;
  logic [4:0] link_out;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic [7:0] m_data;
  logic       m_last;
  logic       hdr_err;

  int checks = 0;
  int errors = 0;

  logic [7:0] rx_d [64];
  logic       rx_l [64];
  int         rx_n = 0;
  logic [3:0] last_nib = '0;

  always #5 clk = ~clk;

  nibble_link_rx u_dut (
    .clk(clk), .rst_n(rst_n), .link_in(link_in), .link_out(link_out),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_last(m_last), .hdr_err(hdr_err)
  );

  // transfer seen at negedge completes on the following posedge
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready && rx_n < 64) begin
      rx_d[rx_n] = m_data;
      rx_l[rx_n] = m_last;
      rx_n = rx_n + 1;
    end
  end

  // packets: byte count, bytes (prefix included), prefix error expected
  localparam int NV = 6;
  localparam int VEC_LEN [NV] = '{6, 3, 4, 3, 2, 4};
  localparam logic [7:0] VEC_DAT [NV][6] = '{
    '{8'h08, 8'h00, 8'hA5, 8'h3C, 8'h0F, 8'hF0},
    '{8'h08, 8'h00, 8'h77, 8'h00, 8'h00, 8'h00},
    '{8'h08, 8'h01, 8'h11, 8'h22, 8'h00, 8'h00},
    '{8'h09, 8'h00, 8'h33, 8'h00, 8'h00, 8'h00},
    '{8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h08, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00}};
  localparam bit VEC_ERR [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ack(input logic lvl, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (link_out[4] == lvl) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit ok;
    link_in = {1'b1, b[7:4]};
    wait_ack(1'b1, ok);
    check(ok, "R3 ack rise", link_out[4], 1);
    link_in = {1'b0, b[3:0]};
    wait_ack(1'b0, ok);
    check(ok, "R3 ack fall", link_out[4], 0);
    last_nib = b[3:0];
  endtask

  task automatic end_packet();
    link_in = {1'b0, ~last_nib};
    repeat (30) @(negedge clk);
    link_in = '0;
    repeat (20) @(negedge clk);
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #2 m_ready = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    int exp_n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(link_out == 5'h00, "R1 link_out", link_out, 0);
    check(!m_valid, "R1 m_valid", m_valid, 0);
    check(!hdr_err, "R1 hdr_err", hdr_err, 0);

    // table of packets
    for (int v = 0; v < NV; v++) begin
      base = rx_n;
      for (int j = 0; j < VEC_LEN[v]; j++) send_byte(VEC_DAT[v][j]);
      end_packet();
      exp_n = VEC_ERR[v] ? 0 : VEC_LEN[v] - 2;
      check(rx_n - base == exp_n, "R5/R6/R9 byte count", rx_n - base, exp_n);
      check(hdr_err == VEC_ERR[v], "R6 hdr_err", hdr_err, VEC_ERR[v]);
      if (rx_n - base == exp_n) begin
        for (int k = 0; k < exp_n; k++) begin
          check(rx_d[base+k] == VEC_DAT[v][k+2], "R4 byte value", rx_d[base+k], VEC_DAT[v][k+2]);
          check(rx_l[base+k] == (k == exp_n - 1), "R7 last flag", rx_l[base+k], k == exp_n - 1);
        end
      end
    end

    // R2: short strobe pulse is filtered out
    @(negedge clk);
    link_in = 5'h10;
    repeat (2) @(negedge clk);
    link_in = 5'h00;
    repeat (30) @(negedge clk);
    check(link_out[4] == 1'b0, "R2 glitch ignored", link_out[4], 0);

    // R10: idle data changes with strobe low are ignored
    link_in = 5'h0A;
    repeat (30) @(negedge clk);
    check(link_out[4] == 1'b0, "R10 idle ack", link_out[4], 0);
    check(!m_valid, "R10 idle stream", m_valid, 0);
    link_in = 5'h00;
    repeat (20) @(negedge clk);
    base = rx_n;
    send_byte(8'h08); send_byte(8'h00); send_byte(8'h5A);
    end_packet();
    check(rx_n - base == 1, "R10 packet after idle", rx_n - base, 1);
    if (rx_n - base == 1) check(rx_d[base] == 8'h5A && rx_l[base], "R10 byte", rx_d[base], 8'h5A);

    // R8: back-pressure stalls acknowledge on the third payload byte
    set_ready(1'b0);
    base = rx_n;
    send_byte(8'h08); send_byte(8'h00); send_byte(8'h11); send_byte(8'h22);
    begin
      bit ok;
      link_in = 5'h13;
      wait_ack(1'b1, ok);
      check(ok, "R8 upper nibble acked", link_out[4], 1);
      link_in = 5'h03;
      repeat (40) @(negedge clk);
      check(link_out[4] == 1'b1, "R8 ack held while full", link_out[4], 1);
      check(m_valid && m_data == 8'h11, "R8 held byte", m_data, 8'h11);
      set_ready(1'b1);
      wait_ack(1'b0, ok);
      check(ok, "R8 ack released", link_out[4], 0);
      last_nib = 4'h3;
    end
    end_packet();
    check(rx_n - base == 3, "R8 count", rx_n - base, 3);
    if (rx_n - base == 3) begin
      check(rx_d[base] == 8'h11 && rx_d[base+1] == 8'h22 && rx_d[base+2] == 8'h33,
            "R8 order", rx_d[base+2], 8'h33);
      check(!rx_l[base] && !rx_l[base+1] && rx_l[base+2], "R7 last after stall",
            rx_l[base+2], 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule